// File: doc/BRIEF.md
# Scene-Program Fetch and Branch Controller

This block feeds a deep, fixed-latency execution pipeline with commands from a scene program held in a local command RAM. It issues one command per clock into a pipeline of `PIPE_DEPTH` stages, 14 by default. Each stage is modelled as a valid bit plus a command tag. The intersection maths is not part of this block.

A small last-outcome predictor steers fetch past conditional branches. Branches resolve when they reach the final stage. A wrong guess clears every younger in-flight entry, and fetch restarts at the corrected address.

A run begins with a start pulse and repeats the program for a requested number of passes, as one ray needs. Each pass begins at address 0 and ends when a stop command retires. The predictor keeps its state across passes and across runs, so rays that follow the same path as the previous ray rarely pay the refill penalty. Between runs the host may rewrite the command RAM.

Top module: `rtc_branch_ctrl`

## Requirements
- R1: After reset, busy, done and ret_valid are 0, and retire_cnt and flush_cnt are 0.
- R2: With no branches, the command at address 0 is first seen on ret_valid 16 clock edges after the edge that samples start. Further commands then appear on consecutive cycles, one per cycle.
- R3: A command word is 14 bits. Bits [13:12] are the opcode: 00 and 11 are plain commands, 01 is a conditional branch whose target is bits [11:0], and 10 is stop. cond_in is sampled while a branch is the retiring entry: 1 means taken, 0 means fall through to address+1. Commands retire strictly in program order.
- R4: The predictor holds one bit per branch address, indexed by the low PRED_IDX_W address bits. Every bit starts at not-taken after reset. A bit is written with the actual outcome when its branch retires. flush_cnt counts only mispredicted branches.
- R5: On a misprediction, no wrong-path command retires. The command at the corrected address appears on ret_valid 17 cycles after the branch, so 16 retire slots are lost.
- R6: A retiring stop ends the pass, and nothing fetched after it retires. If passes remain, the next pass starts at address 0 and its first command appears 17 cycles after the stop. num_passes of 0 is treated as 1.
- R7: done is high for exactly one cycle, in the cycle after the final stop retires. busy is high from the cycle after the start edge through the done cycle. retire_cnt counts every retired command, including stops. Both counters are cleared at start and hold their values after the run.
- R8: A write to the command RAM while busy is high has no effect.
- R9: A start pulse while busy is high is ignored and does not begin another run.
- R10: A branch predicted taken redirects fetch with a single bubble and no flush. After warming, the stop at its target appears 2 cycles after the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| num_passes | input | PASS_W | Number of passes over the program |
| cond_in | input | 1 | Branch outcome from the final stage |
| wr_en | input | 1 | Command RAM write strobe |
| wr_addr | input | 12 | Command RAM write address |
| wr_data | input | 14 | Command word to write |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ret_valid | output | 1 | A command retires this cycle |
| ret_pc | output | 12 | Address of the retiring command |
| retire_cnt | output | CNT_W | Commands retired in this run |
| flush_cnt | output | CNT_W | Mispredictions in this run |

## Verification
Straight-line programs pin down the fill latency and the one-per-cycle retire rate. A single forward branch is run three times in turn: against a cold predictor, against a warmed one, and then with the opposite outcome. These three runs separate the refill gap after a flush, the one-bubble redirect on a correct taken guess, and the training of the predictor bit. Multi-pass runs show the restart after a stop. A run disturbed by RAM writes and a second start shows that neither has any effect. Random forward-branching programs with random pass counts and outcomes compare the retired address sequence and both counters against a reference model that keeps its own predictor table.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    parameter int ADDR_W = 12;
    parameter int WORD_W = ADDR_W + 2;

    typedef enum logic [1:0] {
        OP_PLAIN  = 2'b00,
        OP_BRANCH = 2'b01,
        OP_STOP   = 2'b10,
        OP_ALT    = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    // one in-flight entry: valid, predicted direction, opcode, target, address
    typedef struct packed {
        logic              v;
        logic              pred;
        op_e               op;
        logic [ADDR_W-1:0] tgt;
        logic [ADDR_W-1:0] pc;
    } slot_t;
endpackage

// File: rtl/rtc_cmd_store.sv
module rtc_cmd_store #(
    parameter int AW = 12,
    parameter int WW = 14
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/rtc_branch_pred.sv
module rtc_branch_pred #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] last_dir;

    always_ff @(posedge clk) begin
        if (!rst_n)      last_dir <= '0;
        else if (upd_en) last_dir[upd_idx] <= upd_taken;
    end

    assign rd_taken = last_dir[rd_idx];
endmodule

// File: rtl/rtc_issue_pipe.sv
module rtc_issue_pipe
    import rtc_pkg::*;
#(
    parameter int DEPTH = 14
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  kill,
    input  slot_t in_slot,
    output slot_t tail
);
    slot_t stg [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            slot_t feed;
            if (i == 0) begin : g_head
                assign feed = in_slot;
            end else begin : g_body
                assign feed = stg[i-1];
            end
            always_ff @(posedge clk) begin
                if (!rst_n || kill) stg[i] <= '0;
                else                stg[i] <= feed;
            end
        end
    endgenerate

    assign tail = stg[DEPTH-1];
endmodule

// File: rtl/rtc_branch_ctrl.sv
module rtc_branch_ctrl
    import rtc_pkg::*;
#(
    parameter int PIPE_DEPTH = 14,
    parameter int PRED_IDX_W = 6,
    parameter int PASS_W     = 4,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PASS_W-1:0] num_passes,
    input  logic              cond_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              ret_valid,
    output logic [ADDR_W-1:0] ret_pc,
    output logic [CNT_W-1:0]  retire_cnt,
    output logic [CNT_W-1:0]  flush_cnt
);
    state_e            state, state_nx;
    logic              running;
    logic [ADDR_W-1:0] pc, pc_nx;
    logic              ra_v;
    logic [ADDR_W-1:0] ra_pc;
    logic [WORD_W-1:0] rd_word;
    op_e               ra_op;
    logic [ADDR_W-1:0] ra_tgt;
    logic              pred_rd;
    logic              ra_pred_tk;
    slot_t             fb, tail;
    logic [PASS_W-1:0] pass_left;
    logic              last_pass;
    logic              tail_live, tail_br, tail_stop, mispredict, kill_all;
    logic [ADDR_W-1:0] fix_pc;

    assign running = (state == ST_RUN);

    rtc_cmd_store #(.AW(ADDR_W), .WW(WORD_W)) u_store (
        .clk   (clk),
        .we    (wr_en && (state == ST_IDLE)),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (running),
        .raddr (pc),
        .rdata (rd_word)
    );

    assign ra_op  = op_e'(rd_word[WORD_W-1 -: 2]);
    assign ra_tgt = rd_word[ADDR_W-1:0];

    rtc_branch_pred #(.IDX_W(PRED_IDX_W)) u_pred (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (ra_pc[PRED_IDX_W-1:0]),
        .rd_taken  (pred_rd),
        .upd_en    (tail_br),
        .upd_idx   (tail.pc[PRED_IDX_W-1:0]),
        .upd_taken (cond_in)
    );

    rtc_issue_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .kill    (kill_all),
        .in_slot (fb),
        .tail    (tail)
    );

    // resolution at the final stage
    assign tail_live  = running && tail.v;
    assign tail_br    = tail_live && (tail.op == OP_BRANCH);
    assign tail_stop  = tail_live && (tail.op == OP_STOP);
    assign mispredict = tail_br && (cond_in != tail.pred);
    assign fix_pc     = cond_in ? tail.tgt : tail.pc + ADDR_W'(1);
    assign kill_all   = mispredict || tail_stop;
    assign last_pass  = (pass_left <= PASS_W'(1));
    assign ra_pred_tk = running && ra_v && (ra_op == OP_BRANCH) && pred_rd;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (tail_stop && last_pass) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // fetch address selection, oldest event wins
    always_comb begin
        if (!running)        pc_nx = '0;
        else if (mispredict) pc_nx = fix_pc;
        else if (tail_stop)  pc_nx = '0;
        else if (ra_pred_tk) pc_nx = ra_tgt;
        else                 pc_nx = pc + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc         <= '0;
            ra_v       <= 1'b0;
            ra_pc      <= '0;
            fb         <= '0;
            pass_left  <= '0;
            retire_cnt <= '0;
            flush_cnt  <= '0;
        end else begin
            pc      <= pc_nx;
            ra_v    <= running && !kill_all && !ra_pred_tk;
            ra_pc   <= pc;
            fb.v    <= running && ra_v && !kill_all;
            fb.pred <= pred_rd;
            fb.op   <= ra_op;
            fb.tgt  <= ra_tgt;
            fb.pc   <= ra_pc;
            if (state == ST_IDLE && start) begin
                retire_cnt <= '0;
                flush_cnt  <= '0;
                pass_left  <= num_passes;
            end else if (running) begin
                if (tail_live)  retire_cnt <= retire_cnt + CNT_W'(1);
                if (mispredict) flush_cnt  <= flush_cnt + CNT_W'(1);
                if (tail_stop && !last_pass) pass_left <= pass_left - PASS_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        ret_valid = tail_live;
        ret_pc    = tail.pc;
    end
endmodule

// File: rtl/rtc_branch_ctrl_chk.sv
module rtc_branch_ctrl_chk #(
    parameter int PENALTY = 16
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ret_valid,
    input logic running,
    input logic tail_stop,
    input logic mispredict
);
    localparam int GAP_W = $clog2(PENALTY + 1);

    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n)                       gap <= '0;
        else if (mispredict || tail_stop) gap <= GAP_W'(PENALTY);
        else if (gap != '0)               gap <= gap - GAP_W'(1);
    end

    // R5, R6: refill window after a flush or a pass restart shows no retirement
    a_r5_refill_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (gap != '0) |-> !ret_valid);

    a_r6_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tail_stop |=> !ret_valid);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r7_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(tail_stop));

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> busy);
endmodule

bind rtc_branch_ctrl rtc_branch_ctrl_chk #(.PENALTY(PIPE_DEPTH + 2)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .ret_valid  (ret_valid),
    .running    (running),
    .tail_stop  (tail_stop),
    .mispredict (mispredict)
);

// File: tb/rtc_branch_ctrl_test.sv
module rtc_branch_ctrl_test;
    import rtc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [3:0]        num_passes = 4'd1;
    logic              cond_in = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              busy, done, ret_valid;
    logic [ADDR_W-1:0] ret_pc;
    logic [15:0]       retire_cnt, flush_cnt;

    rtc_branch_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start), .num_passes(num_passes),
        .cond_in(cond_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .retire_cnt(retire_cnt), .flush_cnt(flush_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int gcyc = 0, g0 = 0, done_cyc = 0;
    int got_n = 0;
    int got_pc [256];
    int got_cyc [256];
    logic [WORD_W-1:0] prog [64];
    bit   ptab [64];
    int   exp_n = 0, exp_fl = 0;
    int   exp_seq [256];

    always @(posedge clk) gcyc <= gcyc + 1;

    always @(negedge clk) begin
        if (ret_valid && got_n < 256) begin
            got_pc[got_n]  = int'(ret_pc);
            got_cyc[got_n] = gcyc - g0;
            got_n++;
        end
    end

    function automatic logic [WORD_W-1:0] w_plain(int x);
        return {2'b00, 12'(x)};
    endfunction
    function automatic logic [WORD_W-1:0] w_br(int t);
        return {2'b01, 12'(t)};
    endfunction
    function automatic logic [WORD_W-1:0] w_stop();
        return {2'b10, 12'h000};
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic load(int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = ADDR_W'(i); wr_data = prog[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // reference: architectural path and predictor behaviour (R3, R4, R6)
    task automatic model(int passes, bit cond);
        int pc;
        int np;
        exp_n = 0; exp_fl = 0;
        np = (passes == 0) ? 1 : passes;
        for (int p = 0; p < np; p++) begin
            pc = 0;
            for (int g = 0; g < 200; g++) begin
                logic [WORD_W-1:0] w;
                w = prog[pc % 64];
                if (exp_n < 256) exp_seq[exp_n] = pc;
                exp_n++;
                if (w[13:12] == 2'b10) break;
                if (w[13:12] == 2'b01) begin
                    if (ptab[pc % 64] != cond) exp_fl++;
                    ptab[pc % 64] = cond;
                    pc = cond ? int'(w[11:0]) : pc + 1;
                end else begin
                    pc = pc + 1;
                end
            end
        end
    endtask

    task automatic run(int passes, bit cond, bit disturb);
        got_n = 0;
        @(negedge clk);
        start = 1'b1; num_passes = 4'(passes); cond_in = cond;
        @(posedge clk);
        #1 g0 = gcyc;
        @(negedge clk);
        start = 1'b0;
        for (int it = 0; it < 3000; it++) begin
            @(negedge clk);
            if (done) begin
                done_cyc = gcyc - g0;
                break;
            end
            if (disturb && it == 5) begin
                wr_en = 1'b1; wr_addr = '0; wr_data = w_stop();
                start = 1'b1; num_passes = 4'd3;
            end
            if (disturb && it == 6) begin
                wr_en = 1'b0; start = 1'b0; num_passes = 4'(passes);
            end
            if (it == 2999) chk(1'b0, "R7", "done never seen", 0, 1);
        end
    endtask

    task automatic check_run(string tag);
        bit same;
        int bad;
        same = (got_n == exp_n);
        bad = -1;
        for (int i = 0; i < exp_n && i < 256; i++)
            if (same && got_pc[i] != exp_seq[i]) begin same = 0; bad = i; end
        chk(same, {tag, "/R3/R6"}, "retired sequence (count or first bad index)",
            (bad < 0) ? got_n : got_pc[bad], (bad < 0) ? exp_n : exp_seq[bad]);
        chk(int'(retire_cnt) == exp_n, {tag, "/R7"}, "retire_cnt", int'(retire_cnt), exp_n);
        chk(int'(flush_cnt) == exp_fl, {tag, "/R4"}, "flush_cnt", int'(flush_cnt), exp_fl);
    endtask

    task automatic full(int passes, bit cond, string tag);
        model(passes, cond);
        run(passes, cond, 1'b0);
        check_run(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) ptab[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !ret_valid, "R1", "busy|done|ret_valid",
            int'({busy, done, ret_valid}), 0);
        chk(retire_cnt == 0 && flush_cnt == 0, "R1", "counters",
            int'(retire_cnt) + int'(flush_cnt), 0);

        // straight-line program: latency and rate (R2), done timing (R7)
        for (int i = 0; i < 4; i++) prog[i] = w_plain(i * 7 + 1);
        prog[4] = w_stop();
        load(5);
        full(1, 1'b0, "R2");
        chk(got_cyc[0] == 16, "R2", "first retire cycle", got_cyc[0], 16);
        chk(got_cyc[4] == 20, "R2", "back-to-back retire cycle", got_cyc[4], 20);
        chk(done_cyc == 21, "R7", "done cycle", done_cyc, 21);
        @(negedge clk);
        chk(!busy, "R7", "busy after done", int'(busy), 0);

        // multi-pass restart (R6)
        full(3, 1'b0, "R6");
        chk(got_cyc[5] == 37, "R6", "second pass first retire", got_cyc[5], 37);

        // writes and start ignored while busy (R8, R9)
        model(1, 1'b0);
        run(1, 1'b0, 1'b1);
        check_run("R9");
        repeat (40) @(negedge clk);
        chk(got_n == 5 && !busy, "R9", "retirements after stray start", got_n, 5);
        full(1, 1'b0, "R8");
        chk(got_n > 1, "R8", "word at address 0 unchanged by busy write", got_n, 5);

        // single forward branch: cold miss, warm hit, reversed outcome
        prog[0] = w_plain(3); prog[1] = w_br(4); prog[2] = w_plain(5);
        prog[3] = w_plain(6); prog[4] = w_stop();
        load(5);
        full(1, 1'b1, "R5");
        chk(got_cyc[2] == 34, "R5", "corrected target retire cycle", got_cyc[2], 34);
        full(1, 1'b1, "R10");
        chk(got_cyc[2] == 19, "R10", "predicted-taken target retire cycle", got_cyc[2], 19);
        full(1, 1'b0, "R5");
        chk(got_cyc[2] == 34, "R5", "fall-through after miss retire cycle", got_cyc[2], 34);

        // random forward-branching programs
        for (int r = 0; r < 24; r++) begin
            int len;
            len = 6 + int'($urandom % 19);
            for (int i = 0; i < len - 1; i++) begin
                if ($urandom % 10 < 4) begin
                    int t;
                    t = i + 1 + int'($urandom % 4);
                    if (t > len - 1) t = len - 1;
                    prog[i] = w_br(t);
                end else begin
                    prog[i] = {(($urandom % 2) != 0) ? 2'b11 : 2'b00, 12'($urandom)};
                end
            end
            prog[len-1] = w_stop();
            load(len);
            full(1 + int'($urandom % 3), 1'($urandom % 2), "R4");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule